// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This unit sits beside a simple in-order fetch front end and runs counted loops without spending fetch slots or branch penalties on loop bookkeeping. Decode passes it three kinds of loop operation: a guarded start that may skip the body, an unguarded start whose body always runs once, and a loop-closing operation. The remaining trip count lives in a link-register copy, and every change to it is reported on a write-back port so the architectural register file stays in step.

When the loop-closing operation executes and another pass is due, the unit remembers the loop's top and tail addresses. From then on, when fetch reaches the remembered tail, the unit redirects fetch to the top in the same cycle and counts one pass down, so the closing instruction is never fetched again. An interrupt or exception simply throws the remembered pair away. No loop addresses need saving. After the handler returns, fetch reaches the closing instruction again, executes it in the normal way, and the pair is captured again. Interrupts are never delayed until the loop ends.

Top module: `zol_unit`

## Requirements
- R1: After synchronous reset, `loop_cached` is 0, `fetch_redirect` is 0 and `lr_wb_en` is 0.
- R2: A guarded start (`op_kind` = 1) with a nonzero `op_count` writes that count back in the same cycle and does not redirect fetch.
- R3: A guarded start with `op_count` = 0 redirects fetch in the same cycle to `op_target`, which is the loop exit, and writes back 0.
- R4: An unguarded start (`op_kind` = 2) writes `op_count` back and never redirects fetch, even when the count is 0.
- R5: A loop-close operation (`op_kind` = 3) with a count above 1 redirects to `op_target` (the loop top) and writes back count minus 1. From the next cycle, `loop_cached` is 1 with top `op_target` and tail `op_pc`.
- R6: A loop-close operation with a count of 1 or 0 does not redirect. It writes back the count minus 1, held at a floor of 0, and `loop_cached` is 0 from the next cycle.
- R7: While `loop_cached` is 1, a valid fetch at the cached tail address with a count above 1 redirects in the same cycle to the cached top and writes back count minus 1. The cache stays valid.
- R8: A cached-tail hit with a count of 1 or 0 falls through with no redirect. It writes back the floored decrement and clears `loop_cached` for the next cycle.
- R9: In a cycle with `irq_event` high, the unit drops any operation and any cached hit: there is no redirect and no write-back, the count is unchanged, and `loop_cached` is 0 from the next cycle. A loop-close operation executed later captures the pair again.
- R10: Any start operation clears an existing cached pair, so `loop_cached` is 0 from the next cycle.
- R11: When a valid operation and a cached-tail hit occur in the same cycle, only the operation takes effect.
- R12: The unit ignores a fetch that does not match the cached tail, a matching address with `fetch_valid` low, and `op_valid` with `op_kind` = 0. None of these redirects, writes back, or changes the count or the cache.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A decoded loop operation is present |
| op_kind | input | 2 | 0 none, 1 guarded start, 2 unguarded start, 3 loop close |
| op_count | input | 32 | Trip count operand of a start operation |
| op_target | input | 32 | Loop exit address for a start, loop top address for a close |
| op_pc | input | 32 | Address of the loop-close instruction (the cached tail) |
| fetch_valid | input | 1 | Fetch is presenting an address this cycle |
| fetch_pc | input | 32 | Current fetch address |
| irq_event | input | 1 | Interrupt or exception taken this cycle |
| fetch_redirect | output | 1 | Redirect fetch this cycle |
| redirect_target | output | 32 | Address to redirect fetch to, 0 when idle |
| lr_wb_en | output | 1 | Link-register write-back valid |
| lr_wb_data | output | 32 | Updated link-register value |
| loop_cached | output | 1 | A loop top/tail pair is held |

## Verification
The assertions assume that `op_kind` is stable and meaningful only while `op_valid` is high, and that the front end never presents a cached-tail fetch and a decoded operation that contradict each other in a way the priority rule cannot resolve. The same-cycle collisions are left to R9 and R11. They also assume that `fetch_pc` compares by exact equality against the stored tail. The stimulus drives all inputs once per cycle, half a period away from the sampling edge, and holds unused fields at zero. Deliberate collisions are applied only to test the priority of interrupt over operation over cached hit.

// File: rtl/zol_pkg.sv
package zol_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned CNT_W  = 32;
    localparam int unsigned KIND_W = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [KIND_W-1:0] {
        LOP_NONE  = 2'd0,
        LOP_GUARD = 2'd1,
        LOP_ONCE  = 2'd2,
        LOP_CLOSE = 2'd3
    } loop_op_e;

    typedef struct packed {
        logic  valid;
        addr_t top;
        addr_t tail;
    } loop_entry_t;

    typedef struct packed {
        logic  load;
        cnt_t  load_val;
        logic  dec;
        logic  fill;
        addr_t fill_top;
        addr_t fill_tail;
        logic  clear;
        logic  redirect;
        addr_t target;
    } loop_act_t;

    // Count after one more pass is consumed; never wraps below zero.
    function automatic cnt_t floor_dec(cnt_t c);
        return (c == '0) ? '0 : c - cnt_t'(1);
    endfunction

    // True when the pass now ending is not the last one.
    function automatic logic pass_remains(cnt_t c);
        return c > cnt_t'(1);
    endfunction

    function automatic logic is_start(loop_op_e k);
        return (k == LOP_GUARD) || (k == LOP_ONCE);
    endfunction

endpackage

// File: rtl/zol_count.sv
module zol_count
    import zol_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_en,
    input  cnt_t load_val,
    input  logic dec_en,
    output cnt_t count
);

    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (dec_en) begin
            cnt_q <= floor_dec(cnt_q);
        end
    end

    assign count = cnt_q;

    // R2 / R4: a start operation lands its operand in the count
    a_r2_load_lands: assert property (@(posedge clk) disable iff (rst)
        load_en |=> cnt_q == $past(load_val));

    // R7: a consumed pass removes exactly one from a nonzero count
    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
        (dec_en && !load_en && cnt_q != '0) |=> cnt_q == $past(cnt_q) - cnt_t'(1));

    // R6 / R8: the count never wraps past zero
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (dec_en && !load_en && cnt_q == '0) |=> cnt_q == '0);

    // R9 / R12: with no action the count holds
    a_r12_count_holds: assert property (@(posedge clk) disable iff (rst)
        (!dec_en && !load_en) |=> $stable(cnt_q));

endmodule

// File: rtl/zol_cache.sv
module zol_cache
    import zol_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fill_en,
    input  addr_t fill_top,
    input  addr_t fill_tail,
    input  logic  clear_en,
    input  logic  fetch_valid,
    input  addr_t fetch_pc,
    output logic  valid,
    output addr_t top,
    output logic  hit
);

    loop_entry_t ent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else if (fill_en) begin
            ent_q.valid <= 1'b1;
            ent_q.top   <= fill_top;
            ent_q.tail  <= fill_tail;
        end else if (clear_en) begin
            ent_q.valid <= 1'b0;
        end
    end

    assign valid = ent_q.valid;
    assign top   = ent_q.top;
    assign hit   = ent_q.valid && fetch_valid && (fetch_pc == ent_q.tail);

    // R5: a fill leaves a valid entry holding the given addresses
    a_r5_fill_captures: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> ent_q.valid && ent_q.top == $past(fill_top)
                    && ent_q.tail == $past(fill_tail));

    // R9 / R10: a clear with no fill empties the entry
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clear_en && !fill_en) |=> !ent_q.valid);

    // R12: the stored addresses only move on a fill
    a_r12_addr_stable: assert property (@(posedge clk) disable iff (rst)
        !fill_en |=> $stable(ent_q.top) && $stable(ent_q.tail));

    // R12: a hit needs a valid fetch
    a_r12_hit_needs_fetch: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |-> !hit);

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
    import zol_pkg::*;
(
    input  logic      irq_event,
    input  logic      op_valid,
    input  loop_op_e  op_kind,
    input  cnt_t      op_count,
    input  addr_t     op_target,
    input  addr_t     op_pc,
    input  logic      tail_hit,
    input  addr_t     cached_top,
    input  cnt_t      count,
    output loop_act_t act
);

    logic op_live;
    assign op_live = op_valid && (op_kind != LOP_NONE);

    always_comb begin
        act = '0;
        if (irq_event) begin
            // Drop the cached pair; nothing else happens this cycle.
            act.clear = 1'b1;
        end else if (op_live) begin
            unique case (op_kind)
                LOP_GUARD: begin
                    act.load     = 1'b1;
                    act.load_val = op_count;
                    act.clear    = 1'b1;
                    if (op_count == '0) begin
                        act.redirect = 1'b1;
                        act.target   = op_target;
                    end
                end
                LOP_ONCE: begin
                    act.load     = 1'b1;
                    act.load_val = op_count;
                    act.clear    = 1'b1;
                end
                LOP_CLOSE: begin
                    act.dec = 1'b1;
                    if (pass_remains(count)) begin
                        act.redirect  = 1'b1;
                        act.target    = op_target;
                        act.fill      = 1'b1;
                        act.fill_top  = op_target;
                        act.fill_tail = op_pc;
                    end else begin
                        act.clear = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (tail_hit) begin
            act.dec = 1'b1;
            if (pass_remains(count)) begin
                act.redirect = 1'b1;
                act.target   = cached_top;
            end else begin
                act.clear = 1'b1;
            end
        end
    end

endmodule

// File: rtl/zol_unit.sv
module zol_unit
    import zol_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [KIND_W-1:0]   op_kind,
    input  logic [CNT_W-1:0]    op_count,
    input  logic [ADDR_W-1:0]   op_target,
    input  logic [ADDR_W-1:0]   op_pc,
    input  logic                fetch_valid,
    input  logic [ADDR_W-1:0]   fetch_pc,
    input  logic                irq_event,
    output logic                fetch_redirect,
    output logic [ADDR_W-1:0]   redirect_target,
    output logic                lr_wb_en,
    output logic [CNT_W-1:0]    lr_wb_data,
    output logic                loop_cached
);

    loop_op_e  kind;
    loop_act_t act;
    cnt_t      count;
    logic      tail_hit;
    addr_t     cached_top;

    assign kind = loop_op_e'(op_kind);

    zol_ctrl u_ctrl (
        .irq_event  (irq_event),
        .op_valid   (op_valid),
        .op_kind    (kind),
        .op_count   (op_count),
        .op_target  (op_target),
        .op_pc      (op_pc),
        .tail_hit   (tail_hit),
        .cached_top (cached_top),
        .count      (count),
        .act        (act)
    );

    zol_count u_count (
        .clk      (clk),
        .rst      (rst),
        .load_en  (act.load),
        .load_val (act.load_val),
        .dec_en   (act.dec),
        .count    (count)
    );

    zol_cache u_cache (
        .clk         (clk),
        .rst         (rst),
        .fill_en     (act.fill),
        .fill_top    (act.fill_top),
        .fill_tail   (act.fill_tail),
        .clear_en    (act.clear),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .valid       (loop_cached),
        .top         (cached_top),
        .hit         (tail_hit)
    );

    assign fetch_redirect  = act.redirect;
    assign redirect_target = act.target;
    assign lr_wb_en        = act.load | act.dec;
    assign lr_wb_data      = act.load ? act.load_val : floor_dec(count);

    // R9: an interrupt cycle is silent at the ports
    a_r9_irq_silent: assert property (@(posedge clk) disable iff (rst)
        irq_event |-> !fetch_redirect && !lr_wb_en);

    // R9: an interrupt leaves no cached pair behind
    a_r9_irq_flushes: assert property (@(posedge clk) disable iff (rst)
        irq_event |=> !loop_cached);

    // R3: a guarded start with zero trips jumps to the exit
    a_r3_zero_skips: assert property (@(posedge clk) disable iff (rst)
        (!irq_event && op_valid && kind == LOP_GUARD && op_count == '0)
        |-> fetch_redirect && redirect_target == op_target);

    // R4: an unguarded start never branches
    a_r4_once_no_branch: assert property (@(posedge clk) disable iff (rst)
        (op_valid && kind == LOP_ONCE) |-> !fetch_redirect);

    // R10: a start leaves the cache empty
    a_r10_start_flushes: assert property (@(posedge clk) disable iff (rst)
        (!irq_event && op_valid && is_start(kind)) |=> !loop_cached);

    // R8: a last-pass tail hit falls through
    a_r8_last_falls: assert property (@(posedge clk) disable iff (rst)
        (!irq_event && !(op_valid && kind != LOP_NONE) && tail_hit && count <= cnt_t'(1))
        |-> !fetch_redirect);

    // R11: a live operation shadows the cached redirect target
    a_r11_op_first: assert property (@(posedge clk) disable iff (rst)
        (!irq_event && op_valid && kind == LOP_CLOSE && fetch_redirect)
        |-> redirect_target == op_target);

endmodule

// File: tb/test_zol_unit.sv
`timescale 1ns/1ps
module test_zol_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [31:0] op_count = '0;
    logic [31:0] op_target = '0;
    logic [31:0] op_pc = '0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        irq_event = 1'b0;
    logic        fetch_redirect;
    logic [31:0] redirect_target;
    logic        lr_wb_en;
    logic [31:0] lr_wb_data;
    logic        loop_cached;

    always #2 clk = ~clk;

    zol_unit i_zol_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_count(op_count), .op_target(op_target), .op_pc(op_pc),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .irq_event(irq_event),
        .fetch_redirect(fetch_redirect), .redirect_target(redirect_target),
        .lr_wb_en(lr_wb_en), .lr_wb_data(lr_wb_data), .loop_cached(loop_cached)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state
    logic [31:0] m_lr  = '0;
    bit          m_cv  = 0;
    logic [31:0] m_top = '0;
    logic [31:0] m_tail = '0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input bit ov, input logic [1:0] k,
                       input logic [31:0] cnt, input logic [31:0] tgt,
                       input logic [31:0] pc, input bit fv,
                       input logic [31:0] fpc, input bit irq);
        bit e_rd, e_wb, n_cv;
        logic [31:0] e_tgt, e_wbd, n_lr, n_top, n_tail;
        op_valid = ov; op_kind = k; op_count = cnt; op_target = tgt;
        op_pc = pc; fetch_valid = fv; fetch_pc = fpc; irq_event = irq;
        #1;
        e_rd = 0; e_wb = 0; e_tgt = '0; e_wbd = '0;
        n_lr = m_lr; n_cv = m_cv; n_top = m_top; n_tail = m_tail;
        if (irq) begin
            n_cv = 0;
        end else if (ov && k != 2'd0) begin
            if (k == 2'd1 || k == 2'd2) begin
                e_wb = 1; e_wbd = cnt; n_lr = cnt; n_cv = 0;
                if (k == 2'd1 && cnt == 0) begin e_rd = 1; e_tgt = tgt; end
            end else begin
                e_wb = 1;
                e_wbd = (m_lr == 0) ? 32'd0 : m_lr - 1;
                n_lr = e_wbd;
                if (m_lr > 1) begin
                    e_rd = 1; e_tgt = tgt; n_cv = 1; n_top = tgt; n_tail = pc;
                end else n_cv = 0;
            end
        end else if (m_cv && fv && fpc == m_tail) begin
            e_wb = 1;
            e_wbd = (m_lr == 0) ? 32'd0 : m_lr - 1;
            n_lr = e_wbd;
            if (m_lr > 1) begin e_rd = 1; e_tgt = m_top; end
            else n_cv = 0;
        end
        chk(tag, "redirect", {31'd0, fetch_redirect}, {31'd0, e_rd});
        if (e_rd) chk(tag, "target", redirect_target, e_tgt);
        chk(tag, "wb_en", {31'd0, lr_wb_en}, {31'd0, e_wb});
        if (e_wb) chk(tag, "wb_data", lr_wb_data, e_wbd);
        chk(tag, "cached", {31'd0, loop_cached}, {31'd0, m_cv});
        @(posedge clk);
        m_lr = n_lr; m_cv = n_cv; m_top = n_top; m_tail = n_tail;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 2'd0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        idle("R1");
        // R4: unguarded start, count 3
        cyc("R4", 1, 2'd2, 3, 32'h40, 0, 0, 0, 0);
        // R5: close with count 3 fills cache
        cyc("R5", 1, 2'd3, 0, 32'h80, 32'h100, 0, 0, 0);
        idle("R5");
        // R7: cached tail hit
        cyc("R7", 0, 2'd0, 0, 0, 0, 1, 32'h100, 0);
        // R12: non-matching fetch, and matching address without fetch_valid
        cyc("R12", 0, 2'd0, 0, 0, 0, 1, 32'h90, 0);
        cyc("R12", 0, 2'd0, 0, 0, 0, 0, 32'h100, 0);
        cyc("R12", 1, 2'd0, 7, 32'h55, 32'h66, 0, 0, 0);
        // R8: last pass falls through
        cyc("R8", 0, 2'd0, 0, 0, 0, 1, 32'h100, 0);
        idle("R8");
        cyc("R8", 0, 2'd0, 0, 0, 0, 1, 32'h100, 0);
        // R3: guarded start with zero skips
        cyc("R3", 1, 2'd1, 0, 32'h200, 0, 0, 0, 0);
        // R2: guarded start, count 5
        cyc("R2", 1, 2'd1, 5, 32'h2F0, 0, 0, 0, 0);
        cyc("R5", 1, 2'd3, 0, 32'h280, 32'h300, 0, 0, 0);
        cyc("R7", 0, 2'd0, 0, 0, 0, 1, 32'h300, 0);
        // R9: interrupt with operation and hit present
        cyc("R9", 1, 2'd3, 0, 32'h280, 32'h300, 1, 32'h300, 1);
        cyc("R9", 0, 2'd0, 0, 0, 0, 1, 32'h300, 0);
        cyc("R9", 1, 2'd3, 0, 32'h280, 32'h300, 0, 0, 0);
        cyc("R9", 0, 2'd0, 0, 0, 0, 1, 32'h300, 0);
        // R11: operation and hit collide
        cyc("R5", 1, 2'd1, 4, 32'h500, 0, 0, 0, 0);
        cyc("R5", 1, 2'd3, 0, 32'h280, 32'h300, 0, 0, 0);
        cyc("R11", 1, 2'd3, 0, 32'h480, 32'h4C0, 1, 32'h300, 0);
        // R10: start clears cache; unguarded zero does not branch
        cyc("R10", 1, 2'd2, 0, 32'h600, 0, 0, 0, 0);
        idle("R10");
        // R6: close with count 0 stays at 0
        cyc("R6", 1, 2'd3, 0, 32'h700, 32'h740, 0, 0, 0);
        cyc("R6", 1, 2'd2, 1, 0, 0, 0, 0, 0);
        cyc("R6", 1, 2'd3, 0, 32'h700, 32'h740, 0, 0, 0);
        idle("R6");
        // R7: long loop driven by hits
        cyc("R2", 1, 2'd1, 12, 32'h9F0, 0, 0, 0, 0);
        cyc("R5", 1, 2'd3, 0, 32'h900, 32'h980, 0, 0, 0);
        for (int i = 0; i < 12; i++) begin
            cyc("R7", 0, 2'd0, 0, 0, 0, 1, 32'h980, 0);
            cyc("R12", 0, 2'd0, 0, 0, 0, 1, 32'h900 + 32'(i * 4), 0);
        end
        idle("R8");
        done = 1;
        summary();
        $finish;
    end

endmodule